// File: doc/BRIEF.md
# Zero-Compare Branch and Link Unit

This block resolves control transfers for a 32-bit RISC core. Each cycle it may receive one decoded branch request. The request carries a branch kind, the current PC, one register operand, an immediate that is already sign-extended, a link enable and a delay-slot flag. One clock later the block reports three things:

- whether the branch is taken;
- the next PC;
- what to write to the destination register for a call.

It also reports whether the following instruction must be flushed or may run as a delay slot. Every conditional branch tests the single register operand against zero, treated as a signed value. The block does not compare two registers.

The block also holds a machine status register. A return-from-interrupt request sets the interrupt-enable bit in it. Interrupt entry, which would clear that bit, is handled elsewhere. Every output is registered.

Top module: `zbr_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `res_valid`, `taken`, `flush`, `slot_exec` and `link_wr` are 0, and `status` is 0 (interrupts disabled).
- R2: Kind 1 (jump) is always taken. Its `next_pc` is `pc + imm` modulo 2^32, and it appears one cycle after the request.
- R3: A kind-1 request with `link_en` high gives `link_wr`=1 and `link_val` = the request's `pc`. Any other kind, or `link_en` low, gives `link_wr`=0.
- R4: Kind 2 (subroutine return) and kind 3 (interrupt return) are always taken. Their `next_pc` is `opnd + imm` modulo 2^32.
- R5: A valid kind-3 request sets bit `IE_BIT` (bit 1 by default) of `status` at the same edge on which its results are registered. No other request changes `status`.
- R6: Kinds 4 to 9 are taken when the signed `opnd` is, in order, ==0, !=0, <0, <=0, >0 or >=0. A taken conditional branch targets `pc + imm`.
- R7: A request that is not taken gives `next_pc` = `pc + 4`. This covers a failed condition, kind 0 and the unused kinds 10 to 15.
- R8: A taken request with `dslot`=0 gives `flush`=1 and `slot_exec`=0. With `dslot`=1 it gives `flush`=0 and `slot_exec`=1. A request that is not taken gives 0 on both.
- R9: When `req_valid` is low, the next cycle has `res_valid`, `taken`, `flush`, `slot_exec` and `link_wr` at 0, and `status` keeps its value even if the kind is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A branch request is present |
| br_kind | input | 4 | Decoded branch kind (see R2 to R7) |
| pc | input | 32 | PC of the branch instruction |
| opnd | input | 32 | Register operand |
| imm | input | 32 | Sign-extended immediate |
| link_en | input | 1 | Call form: write the PC to the destination register |
| dslot | input | 1 | Delay-slot variant |
| res_valid | output | 1 | Result registered from a valid request |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Address of the next instruction after the branch |
| link_wr | output | 1 | Destination register write enable |
| link_val | output | 32 | Value for the destination register |
| flush | output | 1 | Discard the following instruction |
| slot_exec | output | 1 | The following instruction runs as a delay slot |
| status | output | 32 | Machine status register |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 32-bit status register and interrupt-enable at bit 1. At this width the signed boundary values 0x80000000, 0x7FFFFFFF, -1, 0 and 1 can be driven exactly. Target sums that wrap past 2^32 are reachable as well. Random kinds include the unused codes 10 and 11, so the fall-back to `pc + 4` is exercised. Idle cycles that carry a kind-3 request show that `status` ignores a request that is not valid.

// File: rtl/zbr_pkg.sv
package zbr_pkg;
  typedef enum logic [3:0] {
    BK_NONE = 4'd0,
    BK_JUMP = 4'd1,
    BK_RET  = 4'd2,
    BK_RETI = 4'd3,
    BK_EQZ  = 4'd4,
    BK_NEZ  = 4'd5,
    BK_LTZ  = 4'd6,
    BK_LEZ  = 4'd7,
    BK_GTZ  = 4'd8,
    BK_GEZ  = 4'd9
  } br_kind_e;

  function automatic logic kind_uncond(input logic [3:0] k);
    return (k == BK_JUMP) || (k == BK_RET) || (k == BK_RETI);
  endfunction

  function automatic logic kind_uses_reg(input logic [3:0] k);
    return (k == BK_RET) || (k == BK_RETI);
  endfunction
endpackage

// File: rtl/zbr_zero_cmp.sv
module zbr_zero_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opnd,
  input  logic [3:0]      kind,
  output logic            cond_true
);
  import zbr_pkg::*;

  logic is_zero;
  logic is_neg;

  assign is_zero = (opnd == '0);
  assign is_neg  = opnd[XLEN-1];

  always_comb begin
    unique case (kind)
      BK_EQZ:  cond_true = is_zero;
      BK_NEZ:  cond_true = !is_zero;
      BK_LTZ:  cond_true = is_neg;
      BK_LEZ:  cond_true = is_neg || is_zero;
      BK_GTZ:  cond_true = !is_neg && !is_zero;
      BK_GEZ:  cond_true = !is_neg;
      default: cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/zbr_target.sv
module zbr_target #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] opnd,
  input  logic [XLEN-1:0] imm,
  input  logic            use_reg,
  output logic [XLEN-1:0] tgt,
  output logic [XLEN-1:0] seq
);
  localparam int STEP = XLEN / 8;
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] base;

  assign base = use_reg ? opnd : pc;
  assign tgt  = base + imm;
  assign seq  = pc + STEP_V;
endmodule

// File: rtl/zbr_status.sv
module zbr_status #(
  parameter int STAT_W = 32,
  parameter int IE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_ie,
  output logic [STAT_W-1:0] status
);
  localparam logic [STAT_W-1:0] IE_MASK = STAT_W'(1) << IE_BIT;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else if (set_ie) status <= status | IE_MASK;
  end

  // R5
  status_only_on_reti_chk: assert property (@(posedge clk) disable iff (rst)
    (status != $past(status)) |-> $past(set_ie));

  // R5
  ie_set_after_reti_chk: assert property (@(posedge clk) disable iff (rst)
    set_ie |=> status[IE_BIT]);
endmodule

// File: rtl/zbr_unit.sv
module zbr_unit #(
  parameter int XLEN   = 32,
  parameter int STAT_W = 32,
  parameter int IE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        br_kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   opnd,
  input  logic [XLEN-1:0]   imm,
  input  logic              link_en,
  input  logic              dslot,
  output logic              res_valid,
  output logic              taken,
  output logic [XLEN-1:0]   next_pc,
  output logic              link_wr,
  output logic [XLEN-1:0]   link_val,
  output logic              flush,
  output logic              slot_exec,
  output logic [STAT_W-1:0] status
);
  import zbr_pkg::*;

  logic            cond_true;
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] seq;
  logic            take_c;
  logic            link_c;
  logic            reti_c;

  zbr_zero_cmp #(.XLEN(XLEN)) u_cmp (
    .opnd      (opnd),
    .kind      (br_kind),
    .cond_true (cond_true)
  );

  zbr_target #(.XLEN(XLEN)) u_tgt (
    .pc      (pc),
    .opnd    (opnd),
    .imm     (imm),
    .use_reg (kind_uses_reg(br_kind)),
    .tgt     (tgt),
    .seq     (seq)
  );

  assign take_c = req_valid && (kind_uncond(br_kind) || cond_true);
  assign link_c = req_valid && link_en && (br_kind == BK_JUMP);
  assign reti_c = req_valid && (br_kind == BK_RETI);

  zbr_status #(.STAT_W(STAT_W), .IE_BIT(IE_BIT)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_ie (reti_c),
    .status (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      link_wr   <= 1'b0;
      link_val  <= '0;
      flush     <= 1'b0;
      slot_exec <= 1'b0;
    end else begin
      res_valid <= req_valid;
      taken     <= take_c;
      next_pc   <= take_c ? tgt : seq;
      link_wr   <= link_c;
      link_val  <= pc;
      flush     <= take_c && !dslot;
      slot_exec <= take_c && dslot;
    end
  end

  // R8
  flush_slot_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flush && slot_exec));

  // R8
  flush_needs_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (flush || slot_exec) |-> taken);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!taken && !link_wr && !flush && !slot_exec));

  // R3
  link_only_jump_chk: assert property (@(posedge clk) disable iff (rst)
    link_wr |-> (taken && $past(br_kind) == BK_JUMP && link_val == $past(pc)));

  // R7
  seq_when_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !taken) |-> (next_pc == $past(pc) + XLEN'(XLEN / 8)));
endmodule

// File: tb/zbr_unit_tb.sv
module zbr_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [3:0]  br_kind;
  logic [31:0] pc, opnd, imm;
  logic        link_en, dslot;
  logic        res_valid, taken, link_wr, flush, slot_exec;
  logic [31:0] next_pc, link_val, status;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_status;

  always #10 clk = ~clk;

  zbr_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .br_kind(br_kind),
    .pc(pc), .opnd(opnd), .imm(imm), .link_en(link_en), .dslot(dslot),
    .res_valid(res_valid), .taken(taken), .next_pc(next_pc),
    .link_wr(link_wr), .link_val(link_val), .flush(flush),
    .slot_exec(slot_exec), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic f_taken(input logic [3:0] k, input logic [31:0] v);
    case (k)
      4'd1, 4'd2, 4'd3: return 1'b1;
      4'd4: return $signed(v) == 0;
      4'd5: return $signed(v) != 0;
      4'd6: return $signed(v) < 0;
      4'd7: return $signed(v) <= 0;
      4'd8: return $signed(v) > 0;
      4'd9: return $signed(v) >= 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic v, input logic [3:0] k, input logic [31:0] p,
                      input logic [31:0] o, input logic [31:0] im,
                      input logic le, input logic ds);
    logic tk;
    logic [31:0] np;
    @(negedge clk);
    req_valid = v; br_kind = k; pc = p; opnd = o; imm = im; link_en = le; dslot = ds;
    tk = v && f_taken(k, o);
    if (!tk) np = p + 32'd4;
    else if (k == 4'd2 || k == 4'd3) np = o + im;
    else np = p + im;
    if (v && k == 4'd3) exp_status = exp_status | 32'h2;
    @(negedge clk);
    if (!v) begin
      chk("R9 res_valid", {31'd0, res_valid}, 32'd0);
      chk("R9 taken", {31'd0, taken}, 32'd0);
      chk("R9 flush", {31'd0, flush | slot_exec | link_wr}, 32'd0);
      chk("R9 status", status, exp_status);
    end else begin
      chk("R6 taken", {31'd0, taken}, {31'd0, tk});
      if (!tk) chk("R7 next_pc", next_pc, np);
      else if (k == 4'd2 || k == 4'd3) chk("R4 next_pc", next_pc, np);
      else if (k == 4'd1) chk("R2 next_pc", next_pc, np);
      else chk("R6 next_pc", next_pc, np);
      chk("R3 link_wr", {31'd0, link_wr}, {31'd0, le && k == 4'd1});
      if (le && k == 4'd1) chk("R3 link_val", link_val, p);
      chk("R8 flush", {31'd0, flush}, {31'd0, tk && !ds});
      chk("R8 slot_exec", {31'd0, slot_exec}, {31'd0, tk && ds});
      chk("R5 status", status, exp_status);
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pick [5];
    void'($urandom(32'h5EED1234));
    rst = 1'b1; req_valid = 1'b0; br_kind = 4'd0; pc = '0; opnd = '0;
    imm = '0; link_en = 1'b0; dslot = 1'b0; exp_status = '0;
    repeat (3) @(negedge clk);
    // R1 while in reset
    chk("R1 status", status, 32'd0);
    chk("R1 flags", {27'd0, res_valid, taken, flush, slot_exec, link_wr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {27'd0, res_valid, taken, flush, slot_exec, link_wr}, 32'd0);
    // directed corners
    step(1, 4'd1, 32'h0000_1000, 32'h0, 32'hFFFF_FFF0, 1, 0);  // R2 backward jump, R3 link
    step(1, 4'd1, 32'hFFFF_FFF8, 32'h0, 32'h0000_0010, 0, 1);  // R2 wrap, R8 slot
    step(1, 4'd2, 32'h0000_2000, 32'h0000_4000, 32'h8, 1, 1);  // R4, R3 ignored
    step(0, 4'd3, 32'h0, 32'h0, 32'h0, 0, 0);                  // R9 invalid reti
    step(1, 4'd3, 32'h0000_3000, 32'h0000_0100, 32'h0, 0, 0);  // R4 R5
    step(1, 4'd4, 32'h100, 32'h0, 32'h40, 1, 0);               // R6 eq taken, R3 ignored
    step(1, 4'd4, 32'h100, 32'h1, 32'h40, 0, 0);               // R7 not taken
    step(1, 4'd6, 32'h200, 32'h8000_0000, 32'h20, 0, 1);       // R6 lt min
    step(1, 4'd8, 32'h200, 32'h7FFF_FFFF, 32'h20, 0, 0);       // R6 gt max
    step(1, 4'd7, 32'h300, 32'h0, 32'h4, 0, 0);                // R6 le zero
    step(1, 4'd8, 32'h300, 32'h0, 32'h4, 0, 0);                // R6 gt zero not taken
    step(1, 4'd9, 32'h300, 32'hFFFF_FFFF, 32'h4, 0, 0);        // R6 ge -1 not taken
    step(1, 4'd5, 32'h300, 32'hFFFF_FFFF, 32'h4, 0, 1);        // R6 ne
    step(1, 4'd12, 32'h400, 32'h0, 32'h4, 1, 0);               // R7 unused kind
    step(1, 4'd0, 32'h500, 32'h0, 32'h4, 0, 0);                // R7 none
    // random
    for (int i = 0; i < 400; i++) begin
      pick[0] = 32'h0; pick[1] = 32'h1; pick[2] = 32'hFFFF_FFFF;
      pick[3] = 32'h8000_0000; pick[4] = $urandom;
      step(($urandom % 8) != 0, 4'($urandom % 12), $urandom & 32'hFFFF_FFFC,
           pick[$urandom % 5], $urandom, 1'($urandom), 1'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule